// File: doc/BRIEF.md
# SMRAM Address Decode and Redirect Unit

This unit is part of the system logic. It looks at every physical memory access and sends it either to the protected management RAM or to ordinary system RAM. The decision uses four things: the address, the identity of the bus master making the access, the processor's management-mode status line, and a manual load control. Only the processor reaches management RAM, and only while it is in management mode or while the load control is on. The load control lets boot firmware copy handler code into that memory from normal mode. Accesses from DMA engines and other masters that fall inside the window are always sent to system RAM.

The window is a naturally aligned block whose size is a power of two. After reset it covers 32 KB at 38000h–3FFFFh. Software can program a new base and size exponent. A size exponent outside the supported range falls back to 32 KB, and the window then sits on the 32 KB block that contains the programmed base. A third output marks accesses that land in the 512-byte context-save zone: offsets 7E00h–7FFFh of the window's lowest 32 KB, which is 3FE00h–3FFFFh for the default window. Handler entry is at offset 0. All outputs are registered and appear one cycle after the access is presented.

Top module: `smram_decode`

## Requirements
- R1: While reset is high, and in the first cycle after it, all three outputs are low. Reset programs the window base to DEF_BASE (38000h) and the size exponent to 15 (32 KB).
- R2: A valid access from master ID CPU_ID (0) whose address is inside the window, presented while smm_active is high, raises cs_smram one cycle later.
- R3: A valid access from any master ID other than CPU_ID is routed to cs_sysram, whatever its address and whatever the state of smm_active and load_en.
- R4: When smm_active is low and load_en is high, valid CPU accesses inside the window raise cs_smram.
- R5: When smm_active and load_en are both low, every valid access raises cs_sysram.
- R6: A valid access whose address is outside the window raises cs_sysram.
- R7: A cycle with cfg_we high loads cfg_base and cfg_size_log2, and the new window applies from the next access. The window is the aligned block of 2^size bytes that contains cfg_base, so the low base bits are ignored.
- R8: A size exponent below 15 or above ADDR_W is replaced by 15, which gives a 32 KB window.
- R9: Each valid access raises exactly one of cs_smram and cs_sysram one cycle later. A cycle with acc_valid low raises neither.
- R10: save_zone is high exactly when cs_smram is high and the access offset from the window base is in 7E00h–7FFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the window configuration |
| cfg_base | input | ADDR_W | Window base (low bits ignored) |
| cfg_size_log2 | input | SZ_W | Window size exponent |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Physical address |
| acc_master | input | MASTER_W | Bus-master identifier |
| smm_active | input | 1 | Processor is in management mode |
| load_en | input | 1 | Manual handler-load control |
| cs_smram | output | 1 | Select for management RAM |
| cs_sysram | output | 1 | Select for system RAM |
| save_zone | output | 1 | SMRAM access falls in the context-save zone |

## Verification
The bench builds the unit with a 20-bit address and a 2-bit master ID. With those values the exponent range 15–20 is small enough that one valid window can cover the whole address space, and exponents 21 and above exercise the fallback. For each of five configurations, the bench sweeps the full address space in 2 KB steps under all sixteen combinations of master, mode and load control. It adds exact probes one byte on either side of every window edge and every save-zone edge.

// File: rtl/smram_pkg.sv
package smram_pkg;
  typedef enum logic [1:0] {
    RT_NONE  = 2'd0,
    RT_SYS   = 2'd1,
    RT_SMRAM = 2'd2
  } route_t;
endpackage

// File: rtl/smram_cfg_regs.sv
module smram_cfg_regs #(
  parameter int ADDR_W   = 32,
  parameter int SZ_W     = 6,
  parameter int MIN_LOG2 = 15,
  parameter logic [ADDR_W-1:0] DEF_BASE = 'h38000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [SZ_W-1:0]   cfg_size_log2,
  output logic [ADDR_W-1:0] win_base,
  output logic [ADDR_W-1:0] win_mask
);
  localparam logic [SZ_W-1:0] LO = SZ_W'(MIN_LOG2);
  localparam logic [SZ_W-1:0] HI = SZ_W'(ADDR_W);

  logic [SZ_W-1:0] log2_q;
  logic [SZ_W-1:0] log2_eff;

  // out-of-range exponents collapse to the minimum window
  always_comb begin
    if (cfg_size_log2 >= LO && cfg_size_log2 <= HI) log2_eff = cfg_size_log2;
    else                                            log2_eff = LO;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_base <= DEF_BASE;
      log2_q   <= LO;
    end else if (cfg_we) begin
      win_base <= cfg_base;
      log2_q   <= log2_eff;
    end
  end

  // mask keeps the address bits that select the aligned block
  for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
    assign win_mask[i] = (SZ_W'(i) >= log2_q);
  end
endmodule

// File: rtl/smram_window_match.sv
module smram_window_match #(
  parameter int ADDR_W    = 32,
  parameter int MIN_LOG2  = 15,
  parameter int SAVE_LOG2 = 9
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] win_base,
  input  logic [ADDR_W-1:0] win_mask,
  output logic              hit,
  output logic              save_hit
);
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] upper;

  assign hit    = (((addr ^ win_base) & win_mask) == '0);
  assign offset = addr & ~win_mask;
  assign upper  = offset >> MIN_LOG2;
  // top slice of the lowest minimum-size block of the window
  assign save_hit = (&offset[MIN_LOG2-1:SAVE_LOG2]) && (upper == '0);
endmodule

// File: rtl/smram_route.sv
module smram_route
  import smram_pkg::*;
#(
  parameter int MASTER_W = 2,
  parameter int CPU_ID   = 0
) (
  input  logic                acc_valid,
  input  logic                hit,
  input  logic [MASTER_W-1:0] acc_master,
  input  logic                smm_active,
  input  logic                load_en,
  output route_t              route
);
  logic is_cpu;
  logic open_path;

  assign is_cpu    = (acc_master == MASTER_W'(CPU_ID));
  assign open_path = smm_active || load_en;

  always_comb begin
    if (!acc_valid)                      route = RT_NONE;
    else if (hit && is_cpu && open_path) route = RT_SMRAM;
    else                                 route = RT_SYS;
  end
endmodule

// File: rtl/smram_decode.sv
module smram_decode
  import smram_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MASTER_W  = 2,
  parameter int CPU_ID    = 0,
  parameter int MIN_LOG2  = 15,
  parameter int SAVE_LOG2 = 9,
  parameter logic [ADDR_W-1:0] DEF_BASE = 'h38000,
  localparam int SZ_W = $clog2(ADDR_W + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_base,
  input  logic [SZ_W-1:0]     cfg_size_log2,
  input  logic                acc_valid,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic [MASTER_W-1:0] acc_master,
  input  logic                smm_active,
  input  logic                load_en,
  output logic                cs_smram,
  output logic                cs_sysram,
  output logic                save_zone
);
  logic [ADDR_W-1:0] win_base;
  logic [ADDR_W-1:0] win_mask;
  logic              hit;
  logic              save_hit;
  route_t            route;

  smram_cfg_regs #(
    .ADDR_W(ADDR_W), .SZ_W(SZ_W), .MIN_LOG2(MIN_LOG2), .DEF_BASE(DEF_BASE)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_base(cfg_base),
    .cfg_size_log2(cfg_size_log2), .win_base(win_base), .win_mask(win_mask)
  );

  smram_window_match #(
    .ADDR_W(ADDR_W), .MIN_LOG2(MIN_LOG2), .SAVE_LOG2(SAVE_LOG2)
  ) u_match (
    .addr(acc_addr), .win_base(win_base), .win_mask(win_mask),
    .hit(hit), .save_hit(save_hit)
  );

  smram_route #(
    .MASTER_W(MASTER_W), .CPU_ID(CPU_ID)
  ) u_route (
    .acc_valid(acc_valid), .hit(hit), .acc_master(acc_master),
    .smm_active(smm_active), .load_en(load_en), .route(route)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_smram  <= 1'b0;
      cs_sysram <= 1'b0;
      save_zone <= 1'b0;
    end else begin
      cs_smram  <= (route == RT_SMRAM);
      cs_sysram <= (route == RT_SYS);
      save_zone <= (route == RT_SMRAM) && save_hit;
    end
  end
endmodule

// File: rtl/smram_decode_chk.sv
module smram_decode_chk #(
  parameter int MASTER_W = 2,
  parameter int CPU_ID   = 0
) (
  input logic                clk,
  input logic                rst,
  input logic                acc_valid,
  input logic [MASTER_W-1:0] acc_master,
  input logic                smm_active,
  input logic                load_en,
  input logic                cs_smram,
  input logic                cs_sysram,
  input logic                save_zone
);
  assert_cs_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(cs_smram && cs_sysram));

  assert_valid_selects_R9: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> (cs_smram || cs_sysram));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !(cs_smram || cs_sysram));

  assert_foreign_master_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_master != MASTER_W'(CPU_ID)) |=> cs_sysram);

  assert_closed_path_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !smm_active && !load_en) |=> cs_sysram);

  assert_save_inside_R10: assert property (@(posedge clk) disable iff (rst)
    save_zone |-> cs_smram);
endmodule

bind smram_decode smram_decode_chk #(.MASTER_W(MASTER_W), .CPU_ID(CPU_ID)) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_master(acc_master),
  .smm_active(smm_active), .load_en(load_en), .cs_smram(cs_smram),
  .cs_sysram(cs_sysram), .save_zone(save_zone)
);

// File: tb/tb_smram_decode.sv
module tb_smram_decode;
  localparam int AW = 20;
  localparam int MW = 2;
  localparam int SW = $clog2(AW + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [SW-1:0] cfg_size_log2 = '0;
  logic          acc_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [MW-1:0] acc_master = '0;
  logic          smm_active = 1'b0;
  logic          load_en = 1'b0;
  logic          cs_smram, cs_sysram, save_zone;

  int     n_cmp = 0;
  int     n_bad = 0;
  bit     done  = 0;
  longint exp_base = 'h38000;
  int     exp_l = 15;

  always #10 clk = ~clk;

  smram_decode #(.ADDR_W(AW), .MASTER_W(MW), .CPU_ID(0), .MIN_LOG2(15),
                 .SAVE_LOG2(9), .DEF_BASE(20'h38000)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_base(cfg_base),
    .cfg_size_log2(cfg_size_log2), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_master(acc_master), .smm_active(smm_active), .load_en(load_en),
    .cs_smram(cs_smram), .cs_sysram(cs_sysram), .save_zone(save_zone)
  );

  task automatic cmp(input string req, input logic act, input logic exp, input longint a);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%05h actual=%b expected=%b", req, a, act, exp);
    end
  endtask

  // R7 R8: program window, model the effective exponent
  task automatic set_cfg(input longint b, input int l);
    cfg_we = 1'b1;
    cfg_base = AW'(b);
    cfg_size_log2 = SW'(l);
    acc_valid = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0;
    exp_base = b;
    exp_l = (l >= 15 && l <= AW) ? l : 15;
  endtask

  task automatic access(input logic v, input longint a, input int m,
                        input logic s, input logic ld, input string tag);
    longint sz, b, off;
    logic hit, to_sm, e_sm, e_sys, e_sv;
    acc_valid = v;
    acc_addr = AW'(a);
    acc_master = MW'(m);
    smm_active = s;
    load_en = ld;
    sz = longint'(1) << exp_l;
    b = (exp_base % (longint'(1) << AW)) / sz * sz;
    hit = ((a / sz) == (b / sz));
    off = a - b;
    to_sm = v && hit && (m == 0) && (s || ld);
    e_sm = to_sm;
    e_sys = v && !to_sm;
    e_sv = to_sm && off >= 'h7E00 && off <= 'h7FFF;
    @(negedge clk);
    cmp({tag, " cs_smram"}, cs_smram, e_sm, a);
    cmp({tag, " cs_sysram"}, cs_sysram, e_sys, a);
    cmp("R10 save_zone", save_zone, e_sv, a);
  endtask

  task automatic sweep_cfg();
    longint sz, b;
    longint probes[8];
    sz = longint'(1) << exp_l;
    b = exp_base / sz * sz;
    probes = '{b - 1, b, b + 'h7DFF, b + 'h7E00, b + 'h7FFF, b + 'h8000, b + sz - 1, b + sz};
    // coarse sweep: R2 R4 R5 R6 R3 R9
    for (longint a = 0; a < (longint'(1) << AW); a += 'h800) begin
      for (int c = 0; c < 16; c++) begin
        access(1'b1, a + (c * 'h7F), c % 4, c[2], c[3], "R2 R3 R4 R5 R6");
      end
    end
    // exact edges of window and save zone
    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 16; c++) begin
        access(1'b1, probes[p] & ((longint'(1) << AW) - 1), c % 4, c[2], c[3], "R6 R7 edge");
      end
    end
    // idle cycles select nothing: R9
    for (int p = 0; p < 8; p++) begin
      access(1'b0, probes[p] & ((longint'(1) << AW) - 1), 0, 1'b1, 1'b1, "R9 idle");
    end
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: outputs low during reset even with an access presented
    acc_valid = 1'b1;
    acc_addr = 20'h38000;
    smm_active = 1'b1;
    repeat (3) @(negedge clk);
    cmp("R1 cs_smram in reset", cs_smram, 1'b0, 0);
    cmp("R1 cs_sysram in reset", cs_sysram, 1'b0, 0);
    cmp("R1 save_zone in reset", save_zone, 1'b0, 0);
    rst = 1'b0;
    acc_valid = 1'b0;
    @(negedge clk);
    cmp("R1 idle after reset", cs_smram | cs_sysram | save_zone, 1'b0, 0);
    // R1 default window 38000h-3FFFFh, save area 3FE00h-3FFFFh
    access(1'b1, 'h38000, 0, 1'b1, 1'b0, "R1 R2 default entry");
    access(1'b1, 'h3FE00, 0, 1'b1, 1'b0, "R1 R10 default save");
    access(1'b1, 'h37FFF, 0, 1'b1, 1'b0, "R1 R6 below default");
    sweep_cfg();
    set_cfg('h40000, 16);   // R7: 64 KB window
    sweep_cfg();
    set_cfg('h38123, 3);    // R8: too small, falls back; R7 low bits ignored
    sweep_cfg();
    set_cfg('h5ABCD, 20);   // R7: window covers the whole space
    sweep_cfg();
    set_cfg('h80000, 25);   // R8: too large, falls back
    sweep_cfg();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule